// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point numbers in the standard single-precision layout. Bit 31 is the sign, bits 30:23 are the biased exponent and bits 22:0 are the fraction. A `sub` input selects subtraction. Subtraction is done by flipping the sign of the second operand before anything else happens.

The datapath first lines up the two significands by their exponent gap. It then adds or subtracts the magnitudes, depending on the two signs. Finally it normalises the result: one place right after a carry, or left by up to 23 places in a single pass after cancellation. Bits shifted out are dropped, so results are truncated and never rounded.

The result is registered. A valid strobe comes out a fixed, parameterised number of cycles after each accepted input. A new operation can be issued every cycle. Rounding, infinities, NaNs and subnormal results are outside the scope of the block.

Top module: `fpas_unit`

## Requirements
- R1: With `sub`=1 the unit computes a−b by inverting bit 31 of b. With `sub`=0 it computes a+b.
- R2: When the exponent fields differ by more than 23, the operand with the larger exponent is returned unchanged as the result. If that operand is b, it carries its effective sign.
- R3: When the gap is 23 or less, the significand of the smaller-exponent operand is shifted right by the gap, with zeros entering at the top and shifted-out bits discarded. Equal exponents cause no shift.
- R4: With matching effective signs, the aligned significands are added and the result sign is the OR of the two signs.
- R5: With differing effective signs, the smaller aligned significand is subtracted from the larger. The result takes the sign of the operand with the larger significand, or a's sign when they are equal.
- R6: A zero combined magnitude produces the all-zero word 0x00000000.
- R7: A carry into bit 24 of the combined magnitude shifts it right by one place and raises the exponent by one. The dropped bit is lost: there is no rounding.
- R8: When bit 23 of the combined magnitude is clear, the leading one is moved to bit 23 in one pass, and the exponent is reduced by the shift distance (up to 23).
- R9: An operand whose exponent field is 0 contributes a zero significand, with no implied leading 1.
- R10: `out_valid` pulses for exactly one cycle, LATENCY cycles after each cycle with `in_valid` high. Back-to-back inputs give back-to-back outputs, and `result` holds its value while no new output arrives.
- R11: While `rst_n` is low, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and `sub` are valid this cycle |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| sub | input | 1 | 1 selects a−b, 0 selects a+b |
| result | output | 32 | Truncated sum or difference |
| out_valid | output | 1 | `result` carries a new value this cycle |

## Verification
The bench probes the exponent gap on both sides of the bypass threshold. At a gap of exactly 23, a design with an off-by-one threshold would return the large operand and lose the single surviving bit. Full cancellation and one-ulp cancellation are exercised. A faulty zero path would leave a stale exponent or sign, and a shallow leading-one search would leave the hidden bit clear after a 23-place shift. Other vectors cover a carry with an odd low bit, which exposes rounding where truncation is required, and a zero operand close to another operand's exponent, which catches an implied 1 wrongly prepended to zero.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int MAG_W  = SIG_W + 1;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int LZ_W   = $clog2(SIG_W);

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } fp_word_t;
endpackage

// File: rtl/fpas_align.sv
module fpas_align
  import fpas_pkg::*;
(
  input  fp_word_t          op_a,
  input  fp_word_t          op_b,
  input  logic              sub,
  output logic [EXP_W-1:0]  big_exp,
  output logic [SIG_W-1:0]  sig_x,
  output logic [SIG_W-1:0]  sig_y,
  output logic              sign_x,
  output logic              sign_y,
  output logic              bypass,
  output fp_word_t          bypass_word
);
  logic [SIG_W-1:0] full_a, full_b;
  logic [EXP_W-1:0] gap;
  logic             a_big;

  always_comb begin
    // zero exponent field: no implied leading one
    full_a = (op_a.exp != '0) ? {1'b1, op_a.frac} : '0;
    full_b = (op_b.exp != '0) ? {1'b1, op_b.frac} : '0;
    sign_x = op_a.sign;
    sign_y = op_b.sign ^ sub;
    a_big  = (op_a.exp >= op_b.exp);
    gap    = a_big ? (op_a.exp - op_b.exp) : (op_b.exp - op_a.exp);
    bypass = (gap > EXP_W'(FRAC_W));
    big_exp = a_big ? op_a.exp : op_b.exp;
    sig_x  = a_big ? full_a : (full_a >> gap);
    sig_y  = a_big ? (full_b >> gap) : full_b;
    bypass_word = a_big ? op_a : '{sign: sign_y, exp: op_b.exp, frac: op_b.frac};
  end
endmodule

// File: rtl/fpas_combine.sv
module fpas_combine
  import fpas_pkg::*;
(
  input  logic [SIG_W-1:0] sig_x,
  input  logic [SIG_W-1:0] sig_y,
  input  logic             sign_x,
  input  logic             sign_y,
  output logic [MAG_W-1:0] mag,
  output logic             mag_sign
);
  always_comb begin
    if (sign_x == sign_y) begin
      mag      = {1'b0, sig_x} + {1'b0, sig_y};
      mag_sign = sign_x | sign_y;
    end else if (sig_x >= sig_y) begin
      mag      = {1'b0, sig_x - sig_y};
      mag_sign = sign_x;
    end else begin
      mag      = {1'b0, sig_y - sig_x};
      mag_sign = sign_y;
    end
  end
endmodule

// File: rtl/fpas_norm.sv
module fpas_norm
  import fpas_pkg::*;
(
  input  logic [MAG_W-1:0] mag,
  input  logic [EXP_W-1:0] exp_in,
  output logic [SIG_W-1:0] sig_out,
  output logic [EXP_W-1:0] exp_out,
  output logic             is_zero
);
  logic [LZ_W-1:0] lead_zeros;
  logic            hit;

  // priority encoder over the 24 significand bits
  always_comb begin
    lead_zeros = '0;
    hit        = 1'b0;
    for (int i = SIG_W - 1; i >= 0; i--) begin
      if (!hit && mag[i]) begin
        lead_zeros = LZ_W'(SIG_W - 1 - i);
        hit        = 1'b1;
      end
    end
  end

  always_comb begin
    is_zero = (mag == '0);
    if (mag[MAG_W-1]) begin
      sig_out = mag[MAG_W-1:1];
      exp_out = exp_in + EXP_W'(1);
    end else begin
      sig_out = mag[SIG_W-1:0] << lead_zeros;
      exp_out = exp_in - EXP_W'(lead_zeros);
    end
  end
endmodule

// File: rtl/fpas_unit.sv
module fpas_unit
  import fpas_pkg::*;
#(
  parameter int LATENCY = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic        sub,
  output logic [31:0] result,
  output logic        out_valid
);
  localparam int LAST = LATENCY - 1;

  logic [EXP_W-1:0] big_exp, exp_n;
  logic [SIG_W-1:0] sig_x, sig_y, sig_n;
  logic             sign_x, sign_y, bypass, mag_sign, is_zero;
  fp_word_t         bypass_word;
  logic [MAG_W-1:0] mag;
  logic [WORD_W-1:0] res_d;

  fpas_align u_align (
    .op_a(fp_word_t'(a)), .op_b(fp_word_t'(b)), .sub(sub),
    .big_exp(big_exp), .sig_x(sig_x), .sig_y(sig_y),
    .sign_x(sign_x), .sign_y(sign_y), .bypass(bypass), .bypass_word(bypass_word)
  );

  fpas_combine u_combine (
    .sig_x(sig_x), .sig_y(sig_y), .sign_x(sign_x), .sign_y(sign_y),
    .mag(mag), .mag_sign(mag_sign)
  );

  fpas_norm u_norm (
    .mag(mag), .exp_in(big_exp), .sig_out(sig_n), .exp_out(exp_n), .is_zero(is_zero)
  );

  always_comb begin
    if (bypass)       res_d = bypass_word;
    else if (is_zero) res_d = '0;
    else              res_d = {mag_sign, exp_n, sig_n[FRAC_W-1:0]};
  end

  logic [WORD_W-1:0] res_q [LATENCY];
  logic [LATENCY-1:0] vld_q;

  generate
    for (genvar g = 0; g < LATENCY; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) vld_q[0] <= 1'b0;
          else        vld_q[0] <= in_valid;
        end
        always_ff @(posedge clk) begin
          if (in_valid) res_q[0] <= res_d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) vld_q[g] <= 1'b0;
          else        vld_q[g] <= vld_q[g-1];
        end
        always_ff @(posedge clk) begin
          if (vld_q[g-1]) res_q[g] <= res_q[g-1];
        end
        AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
          vld_q[g-1] |=> vld_q[g]); // R10
      end
    end
  endgenerate

  assign result    = res_q[LAST];
  assign out_valid = vld_q[LAST];

  AST_VALID_START: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> vld_q[0]); // R10
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !vld_q[0]); // R10
  AST_BYPASS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bypass) |=> (res_q[0] == $past(bypass_word))); // R2
  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bypass && mag == '0) |=> (res_q[0] == '0)); // R6
  AST_LIKE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bypass && mag != '0 && sign_x == sign_y) |=> (res_q[0][WORD_W-1] == $past(sign_x))); // R4
  AST_NORM_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mag != '0) |-> sig_n[SIG_W-1]); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !out_valid); // R11
endmodule

// File: tb/fpas_unit_test.sv
`timescale 1ns/1ps
module fpas_unit_test;
  localparam int LAT = 2;
  localparam int NV  = 16;

  localparam logic [31:0] VA [NV] = '{
    32'h3FA54FDF, 32'hC0179097, 32'h3F800000, 32'h3F800000,
    32'h3FC00000, 32'h4B800000, 32'h4B000000, 32'h3F800000,
    32'h3F800000, 32'h3F800001, 32'h00000000, 32'h00000000,
    32'hBF800000, 32'h3F800000, 32'h3F800003, 32'h3F800000};
  localparam logic [31:0] VB [NV] = '{
    32'h4115865A, 32'h40CD4952, 32'h3F800000, 32'h3F800000,
    32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h4B800000,
    32'h40000000, 32'h3F800000, 32'h40400000, 32'h0B800000,
    32'hBF800000, 32'hBF800000, 32'h3F800000, 32'hBFC00000};
  localparam logic VS [NV] = '{
    1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1,
    1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [31:0] VE [NV] = '{
    32'h412A3055, 32'h40818107, 32'h40000000, 32'h00000000,
    32'h3F000000, 32'h4B800000, 32'h4B000001, 32'hCB800000,
    32'hBF800000, 32'h34000000, 32'h40400000, 32'h0B800000,
    32'hC0000000, 32'h40000000, 32'h40000001, 32'hBF000000};
  localparam string VR [NV] = '{
    "R3", "R5", "R7", "R1", "R8", "R2", "R3", "R2",
    "R5", "R8", "R9", "R9", "R4", "R1", "R7", "R5"};

  logic clk = 1'b0;
  logic rst_n, in_valid, sub;
  logic [31:0] a, b, result;
  logic out_valid;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  fpas_unit #(.LATENCY(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .sub(sub), .result(result), .out_valid(out_valid));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic run_one(input logic [31:0] va, input logic [31:0] vb, input logic vs,
                         input logic [31:0] ve, input string req);
    @(negedge clk);
    a = va; b = vb; sub = vs; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    check({req, " valid"}, {31'b0, out_valid}, 32'd1);
    check(req, result, ve);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    rst_n = 1'b0; in_valid = 1'b0; sub = 1'b0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    check("R11 reset", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after release", {31'b0, out_valid}, 32'd0);

    for (int i = 0; i < NV; i++)
      run_one(VA[i], VB[i], VS[i], VE[i], VR[i]);

    // R10: one-cycle pulse and held result while idle
    held = result;
    @(negedge clk);
    check("R10 pulse ends", {31'b0, out_valid}, 32'd0);
    repeat (3) @(negedge clk);
    check("R10 held", result, held);

    // R10: back-to-back issue
    @(negedge clk);
    a = 32'h3F800000; b = 32'h3F800000; sub = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    a = 32'h40000000; b = 32'h3F800000; sub = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT - 2) @(negedge clk);
    check("R10 first valid", {31'b0, out_valid}, 32'd1);
    check("R10 first", result, 32'h40000000);
    @(negedge clk);
    check("R10 second valid", {31'b0, out_valid}, 32'd1);
    check("R10 second", result, 32'h3F800000);
    @(negedge clk);
    check("R10 stream end", {31'b0, out_valid}, 32'd0);

    // R6: cancellation clears the sign too
    run_one(32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, "R6");
    // R3: equal exponents, no shift
    run_one(32'h40400000, 32'h40000000, 1'b0, 32'h40A00000, "R3 equal exp");

    // R11: reset mid-stream drops valid
    @(negedge clk);
    a = 32'h3F800000; b = 32'h3F800000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst_n = 1'b0;
    #1;
    check("R11 async", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (LAT) @(negedge clk);
    check("R11 no stale", {31'b0, out_valid}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule